// File: doc/BRIEF.md
# Output Protection Gate with Per-Channel Thermal Hysteresis

This block sits between the output-request register of a multi-rail power module and the pass devices. It has eight output channels: five linear regulators and three high-side switches. Each channel gives a final drive enable that is the software request with two protection terms removed. The first term is a thermal-shutdown state kept per channel with hysteresis. The second is a battery-overvoltage state that applies to every channel at once.

The temperature input is an unsigned code equal to the junction temperature in degrees Celsius plus 40. A code of 0 therefore means -40 °C. The battery input is a code in steps of 0.25 V. Regulator channels 0 to 4 and the two small switches, channels 6 and 7, share one threshold pair. The large switch, channel 5, has a wider window. Current limiting happens in the analog section and has no path into this block. The enables depend only on the request, the temperature code and the battery code.

Top module: `prot_gate`

## Requirements
- R1: An active-low asynchronous reset clears every thermal-shutdown state and the overvoltage state. While reset is held, and right after it is released, each enable equals its request bit.
- R2: A standard channel (indices 0-4, 6, 7) enters shutdown on the clock edge that samples a temperature code of 200 (160 °C) or higher.
- R3: When the temperature code lies strictly between a channel's recovery and trip codes, that channel keeps its shutdown state unchanged.
- R4: A standard channel leaves shutdown on the clock edge that samples a temperature code of 170 (130 °C) or lower.
- R5: The large-switch channel (index 5) trips at code 210 (170 °C) or higher and recovers at code 160 (120 °C) or lower.
- R6: Shutdown states are independent. At codes 200 to 209 the standard channels are off while channel 5 stays enabled.
- R7: A battery code of 108 (27.0 V) or higher sets the overvoltage state on the next clock edge and forces all eight enables low. A code of 107 or lower clears it on the next edge.
- R8: Each en_out bit equals req_en AND NOT tsd_flag AND NOT ov_flag for that bit. The request reaches the output without a register delay.
- R9: tsd_flag and ov_flag are registered: a change in the sensed codes shows on them only after the next rising clock edge.
- R10: The thermal states keep tracking the temperature during overvoltage. When overvoltage clears, the enables reflect the thermal states that were updated meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_en | input | 8 | Requested enable per channel (0-4 regulators, 5 large switch, 6-7 small switches) |
| temp_code | input | 8 | Junction temperature, °C + 40 |
| vbat_code | input | 8 | Battery voltage in 0.25 V steps |
| en_out | output | 8 | Final protected enable per channel |
| tsd_flag | output | 8 | Registered thermal-shutdown state per channel |
| ov_flag | output | 1 | Registered battery-overvoltage state |

## Verification
The bench builds the block with its default parameters: eight channels with the large switch at index 5, 8-bit codes, a 40 °C offset and 0.25 V steps. These values place every threshold at a reachable code. The standard trip and recovery codes are 200 and 170, the large-switch codes are 210 and 160, and the overvoltage code is 108. The bench therefore lands exactly on each edge of both hysteresis windows and on the 107/108 voltage boundary. It also stays inside the 200-209 band where only the standard channels are tripped.

// File: rtl/prot_pkg.sv
package prot_pkg;

  // Degrees Celsius to temperature code, with a configurable offset.
  function automatic int degc_to_code(input int degc, input int ofs);
    return degc + ofs;
  endfunction

  // Millivolts to voltage code, with a step in millivolts (rounds up).
  function automatic int mv_to_code(input int mv, input int lsb_mv);
    return (mv + lsb_mv - 1) / lsb_mv;
  endfunction

  // Next hysteresis state from the current state and the sensed code.
  function automatic logic hyst_next(input logic cur, input logic at_trip,
                                     input logic at_clear);
    if (at_trip)       return 1'b1;
    else if (at_clear) return 1'b0;
    else               return cur;
  endfunction

endpackage

// File: rtl/chan_thermal.sv
module chan_thermal #(
  parameter int CODE_W   = 8,
  parameter int TRIP_CODE = 200,
  parameter int REC_CODE  = 170
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] temp_code,
  output logic              tsd_q
);
  import prot_pkg::*;

  localparam logic [CODE_W-1:0] TRIP_V = CODE_W'(TRIP_CODE);
  localparam logic [CODE_W-1:0] REC_V  = CODE_W'(REC_CODE);

  logic trip_evt;
  logic clear_evt;
  logic hold_evt;

  assign trip_evt  = (temp_code >= TRIP_V);
  assign clear_evt = (temp_code <= REC_V);
  assign hold_evt  = !trip_evt && !clear_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tsd_q <= 1'b0;
    else        tsd_q <= hyst_next(tsd_q, trip_evt, clear_evt);
  end

  // R2
  trip_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip_evt |=> tsd_q);

  // R4
  clear_resets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |=> !tsd_q);

  // R3
  band_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_evt |=> (tsd_q == $past(tsd_q)));

endmodule

// File: rtl/ov_detect.sv
module ov_detect #(
  parameter int CODE_W  = 8,
  parameter int OV_CODE = 108
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] vbat_code,
  output logic              ov_q
);
  localparam logic [CODE_W-1:0] OV_V = CODE_W'(OV_CODE);

  logic over_evt;
  assign over_evt = (vbat_code >= OV_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ov_q <= 1'b0;
    else        ov_q <= over_evt;
  end

  // R7
  ov_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    over_evt |=> ov_q);

  // R7
  ov_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !over_evt |=> !ov_q);

endmodule

// File: rtl/prot_gate.sv
module prot_gate #(
  parameter int NUM_CH      = 8,
  parameter int BIG_CH      = 5,
  parameter int TEMP_W      = 8,
  parameter int VOLT_W      = 8,
  parameter int TEMP_OFS    = 40,
  parameter int STD_TRIP_C  = 160,
  parameter int STD_REC_C   = 130,
  parameter int BIG_TRIP_C  = 170,
  parameter int BIG_REC_C   = 120,
  parameter int OV_MV       = 27000,
  parameter int VOLT_LSB_MV = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_en,
  input  logic [TEMP_W-1:0] temp_code,
  input  logic [VOLT_W-1:0] vbat_code,
  output logic [NUM_CH-1:0] en_out,
  output logic [NUM_CH-1:0] tsd_flag,
  output logic              ov_flag
);
  import prot_pkg::*;

  localparam int STD_TRIP = degc_to_code(STD_TRIP_C, TEMP_OFS);
  localparam int STD_REC  = degc_to_code(STD_REC_C,  TEMP_OFS);
  localparam int BIG_TRIP = degc_to_code(BIG_TRIP_C, TEMP_OFS);
  localparam int BIG_REC  = degc_to_code(BIG_REC_C,  TEMP_OFS);
  localparam int OV_CODE  = mv_to_code(OV_MV, VOLT_LSB_MV);

  logic [NUM_CH-1:0] tsd_state;
  logic              ov_state;
  logic [NUM_CH-1:0] block_mask;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == BIG_CH) begin : g_big
      chan_thermal #(.CODE_W(TEMP_W), .TRIP_CODE(BIG_TRIP), .REC_CODE(BIG_REC))
        u_th (.clk(clk), .rst_n(rst_n), .temp_code(temp_code), .tsd_q(tsd_state[i]));
    end else begin : g_std
      chan_thermal #(.CODE_W(TEMP_W), .TRIP_CODE(STD_TRIP), .REC_CODE(STD_REC))
        u_th (.clk(clk), .rst_n(rst_n), .temp_code(temp_code), .tsd_q(tsd_state[i]));
    end
  end

  ov_detect #(.CODE_W(VOLT_W), .OV_CODE(OV_CODE)) u_ov (
    .clk(clk), .rst_n(rst_n), .vbat_code(vbat_code), .ov_q(ov_state));

  assign block_mask = tsd_state | {NUM_CH{ov_state}};
  assign en_out     = req_en & ~block_mask;
  assign tsd_flag   = tsd_state;
  assign ov_flag    = ov_state;

  // R7
  ov_gates_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag |-> (en_out == '0));

  // R8
  no_spurious_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_out & ~req_en) == '0);

  // R8
  tsd_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_out & tsd_flag) == '0);

endmodule

// File: tb/prot_gate_tb.sv
module prot_gate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_en = 8'h00;
  logic [7:0] temp_code = 8'd65;
  logic [7:0] vbat_code = 8'd56;
  logic [7:0] en_out;
  logic [7:0] tsd_flag;
  logic       ov_flag;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  prot_gate u_dut (.clk(clk), .rst_n(rst_n), .req_en(req_en), .temp_code(temp_code),
                   .vbat_code(vbat_code), .en_out(en_out), .tsd_flag(tsd_flag),
                   .ov_flag(ov_flag));

  // Fields: temp, vbat, req, exp en, exp tsd, exp ov, requirement id
  localparam int NV = 14;
  localparam logic [48:0] VEC [NV] = '{
    {8'd65,  8'd56,  8'hFF, 8'hFF, 8'h00, 1'b0, 8'd8},  // R8 nominal
    {8'd185, 8'd56,  8'hFF, 8'hFF, 8'h00, 1'b0, 8'd3},  // R3 hold off
    {8'd200, 8'd56,  8'hFF, 8'h20, 8'hDF, 1'b0, 8'd2},  // R2 trip std
    {8'd205, 8'd56,  8'hFF, 8'h20, 8'hDF, 1'b0, 8'd6},  // R6 independent
    {8'd210, 8'd56,  8'hFF, 8'h00, 8'hFF, 1'b0, 8'd5},  // R5 big trip
    {8'd185, 8'd56,  8'hFF, 8'h00, 8'hFF, 1'b0, 8'd3},  // R3 hold on
    {8'd170, 8'd56,  8'hFF, 8'hDF, 8'h20, 1'b0, 8'd4},  // R4 std recover
    {8'd165, 8'd56,  8'hFF, 8'hDF, 8'h20, 1'b0, 8'd5},  // R5 big hold
    {8'd160, 8'd56,  8'hFF, 8'hFF, 8'h00, 1'b0, 8'd5},  // R5 big recover
    {8'd65,  8'd56,  8'hA5, 8'hA5, 8'h00, 1'b0, 8'd8},  // R8 pattern
    {8'd65,  8'd107, 8'hA5, 8'hA5, 8'h00, 1'b0, 8'd7},  // R7 below limit
    {8'd65,  8'd108, 8'hA5, 8'h00, 8'h00, 1'b1, 8'd7},  // R7 at limit
    {8'd200, 8'd108, 8'hA5, 8'h00, 8'hDF, 1'b1, 8'd10}, // R10 tracks in OV
    {8'd200, 8'd56,  8'hA5, 8'h20, 8'hDF, 1'b0, 8'd10}  // R10 after OV
  };

  task automatic chk(input string rq, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h", rq, got, exp);
    end
  endtask

  initial begin : watchdog
    #1000000;
    n_fail++;
    $display("FAIL watchdog got=hang exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    string rq;
    // R1: reset state
    req_en = 8'h3C;
    temp_code = 8'd220;
    #12;
    chk("R1 en in reset", en_out, 8'h3C);
    chk("R1 tsd in reset", tsd_flag, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 tsd after release", tsd_flag, 8'h00);
    chk("R1 en after release", en_out, 8'h3C);
    @(negedge clk);
    chk("R2 tsd hot", tsd_flag, 8'hFF);
    // R1: reset clears tripped state
    rst_n = 1'b0;
    #1;
    chk("R1 reset clears tsd", tsd_flag, 8'h00);
    temp_code = 8'd65;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      temp_code = VEC[i][48:41];
      vbat_code = VEC[i][40:33];
      req_en    = VEC[i][32:25];
      @(negedge clk);
      rq = $sformatf("R%0d vec%0d", VEC[i][7:0], i);
      chk({rq, " en"},  en_out,   VEC[i][24:17]);
      chk({rq, " tsd"}, tsd_flag, VEC[i][16:9]);
      chk({rq, " ov"},  {7'd0, ov_flag}, {7'd0, VEC[i][8]});
    end

    // R9: flags change only after a clock edge
    temp_code = 8'd65;
    vbat_code = 8'd56;
    @(negedge clk);
    temp_code = 8'd215;
    vbat_code = 8'd120;
    #1;
    chk("R9 tsd before edge", tsd_flag, 8'h00);
    chk("R9 ov before edge", {7'd0, ov_flag}, 8'h00);
    @(negedge clk);
    chk("R9 tsd after edge", tsd_flag, 8'hFF);
    chk("R9 ov after edge", {7'd0, ov_flag}, 8'h01);

    // R8: request reaches output without delay
    temp_code = 8'd65;
    vbat_code = 8'd56;
    @(negedge clk);
    req_en = 8'h81;
    #1;
    chk("R8 comb request", en_out, 8'h81);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule